// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for each beat of an SDRAM-style burst. A 7-bit mode word is written into an internal mode register. The mode word selects three things: how addresses are ordered (sequential or interleave), how many beats a burst has, and the read latency in clocks. After a start strobe that carries an 8-bit starting column, the block puts out one column address per clock. It stops when the programmed length is reached, or when a terminate input is raised. A full-page burst runs until it is terminated.

For read bursts, a data-valid strobe follows each issued column, delayed by the programmed latency. This lets the surrounding controller know when read data appears on the bus. Illegal mode words raise an error flag, and the flag blocks new bursts until a legal word is written.

Top module: `burst_col_seq`

## Requirements
- R1: `mode_word` is captured on a clock with `mode_we` high. Bits [2:0] select the burst length: 000=1, 001=2, 010=4, 011=8, 111=full page. Bit [3] selects the ordering: 0 is sequential, 1 is interleave. Bits [6:4] select the latency: 001=1, 010=2, 011=3 clocks.
- R2: `mode_err` goes high on the clock after a mode write whose latency code is 000 or 1xx, or whose length code is 100, 101 or 110, or that selects interleave with a length other than 4 or 8. A legal write clears it on the next clock.
- R3: While `mode_err` is high, `start` is ignored and no burst begins.
- R4: An accepted `start` puts `col_addr` equal to `start_col` with `col_valid` high on the next clock. After that, one beat is issued per clock.
- R5: A sequential burst of 1, 2, 4 or 8 beats increments only the low log2(length) address bits. Those bits wrap inside the aligned block and the upper bits are held. `col_valid` stays high for exactly that many beats.
- R6: A sequential full-page burst adds one modulo 256 on every beat, and it keeps going past 256 beats.
- R7: In an interleave burst, beat k issues the starting column XOR k, for 4 or 8 beats.
- R8: When `stop` is high and `start` is low, `col_valid` is low on the next clock.
- R9: A `start` during an active burst aborts that burst. The new column appears on the next clock and the beat count restarts.
- R10: For a read burst, `rd_valid` is high exactly L clocks after each clock on which `col_valid` was high, where L is the programmed latency. For a write burst, `rd_valid` stays low.
- R11: After reset, `col_valid`, `rd_valid` and `mode_err` are low. The mode is then length 1, sequential, latency 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_word | input | 7 | Mode word: latency [6:4], ordering [3], length [2:0] |
| start | input | 1 | Burst start strobe |
| start_col | input | 8 | Starting column address |
| start_read | input | 1 | 1 = read burst, 0 = write burst |
| stop | input | 1 | Terminate the active burst |
| col_addr | output | 8 | Column address of the current beat |
| col_valid | output | 1 | A beat is issued this clock |
| rd_valid | output | 1 | Read data valid, delayed by the latency |
| mode_err | output | 1 | The mode register holds an illegal combination |

## Verification
Sequential bursts of every fixed length are started from all 256 columns. These runs separate in-block wrap from plain increment, and show whether the upper bits are held at block edges such as 7, 255 and odd offsets. Interleave bursts of 4 and 8 are swept over all 256 starts, which tells XOR ordering apart from increment ordering. All 128 mode words are written, and each is checked for the error flag and for start blocking. Separate runs cover a full-page burst crossing 255 for more than 256 beats, a stop in the middle of a burst, a restart in the middle of a burst, and read bursts at each latency. Together these pin down the timing of `rd_valid` and show that it stays low for writes.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int MODE_W = 7;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } ord_e;

  typedef struct packed {
    logic [2:0] lat;
    ord_e       ord;
    logic [2:0] len;
  } mode_t;

  localparam logic [2:0] LEN_FULL = 3'b111;
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mode_we,
  input  logic [MODE_W-1:0]     mode_word,
  output ord_e                  ord,
  output logic [COL_W-1:0]      len_mask,
  output logic                  full_page,
  output logic [2:0]            lat,
  output logic                  err
);
  mode_t mode_q;
  logic  err_q;
  mode_t wr_mode;

  assign wr_mode = mode_t'(mode_word);

  function automatic logic is_bad(input mode_t m);
    logic bad_lat, bad_len, bad_ord;
    bad_lat = (m.lat == 3'b000) || m.lat[2];
    bad_len = (m.len == 3'b100) || (m.len == 3'b101) || (m.len == 3'b110);
    bad_ord = (m.ord == ORD_ILV) && !((m.len == 3'b010) || (m.len == 3'b011));
    return bad_lat || bad_len || bad_ord;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '{lat: 3'b001, ord: ORD_SEQ, len: 3'b000};
      err_q  <= 1'b0;
    end else if (mode_we) begin
      mode_q <= wr_mode;
      err_q  <= is_bad(wr_mode);
    end
  end

  assign ord       = mode_q.ord;
  assign lat       = mode_q.lat;
  assign err       = err_q;
  assign full_page = (mode_q.len == LEN_FULL);

  always_comb begin
    if (full_page) len_mask = '1;
    else           len_mask = (COL_W'(1) << mode_q.len[1:0]) - COL_W'(1);
  end

  AST_ERR_BAD_LAT: assert property (@(posedge clk) disable iff (rst)
    (mode_we && (mode_word[6:4] == 3'b000)) |=> err); // R2
  AST_ERR_ILV_LEN1: assert property (@(posedge clk) disable iff (rst)
    (mode_we && (mode_word[3:0] == 4'b1000)) |=> err); // R2
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_read,
  input  logic             stop,
  input  logic             err,
  input  ord_e             ord,
  input  logic [COL_W-1:0] len_mask,
  input  logic             full_page,
  input  logic [2:0]       lat,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             read_beat,
  output logic [2:0]       lat_q
);
  logic [COL_W-1:0] base_q, beat_q, mask_q, addr_q;
  logic [COL_W-1:0] beat_nx, addr_nx;
  logic             valid_q, rd_q, full_q;
  ord_e             ord_q;
  logic             accept, last;

  assign accept  = start && !err;
  assign last    = !full_q && (beat_q == mask_q);
  assign beat_nx = beat_q + COL_W'(1);

  always_comb begin
    if (ord_q == ORD_ILV) addr_nx = base_q ^ beat_nx;
    else addr_nx = (addr_q & ~mask_q) | ((addr_q + COL_W'(1)) & mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      rd_q    <= 1'b0;
      full_q  <= 1'b0;
      ord_q   <= ORD_SEQ;
      lat_q   <= 3'b001;
    end else if (accept) begin
      valid_q <= 1'b1;
      addr_q  <= start_col;
      base_q  <= start_col;
      beat_q  <= '0;
      mask_q  <= len_mask;
      rd_q    <= start_read;
      full_q  <= full_page;
      ord_q   <= ord;
      lat_q   <= lat;
    end else if (valid_q) begin
      if (stop || last) begin
        valid_q <= 1'b0;
      end else begin
        addr_q <= addr_nx;
        beat_q <= beat_nx;
      end
    end
  end

  assign col_addr  = addr_q;
  assign col_valid = valid_q;
  assign read_beat = valid_q && rd_q;

  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    (start && !err) |=> (col_valid && (col_addr == $past(start_col)))); // R4
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (start && err && !col_valid) |=> !col_valid); // R3
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> !col_valid); // R8
  AST_FULL_STEP: assert property (@(posedge clk) disable iff (rst)
    (col_valid && full_q && (ord_q == ORD_SEQ) && !start && !stop)
      |=> (col_valid && (col_addr == $past(col_addr) + COL_W'(1)))); // R6
  AST_ILV_UPPER: assert property (@(posedge clk) disable iff (rst)
    (col_valid && (ord_q == ORD_ILV) && !start)
      |=> (col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3]))); // R7
  AST_FIXED_END: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !full_q && (beat_q == mask_q) && !start) |=> !col_valid); // R5
endmodule

// File: rtl/bcs_valid_pipe.sv
module bcs_valid_pipe #(
  parameter int LAT_MAX = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       beat_in,
  input  logic [2:0] lat,
  output logic       rd_valid
);
  localparam int STAGES = (LAT_MAX > 1) ? LAT_MAX - 1 : 1;

  logic [STAGES-1:0] stg;
  logic              tap;
  logic              rdv_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= 1'b0;
      else if (i == 0) stg[i] <= beat_in;
      else stg[i] <= stg[(i == 0) ? 0 : i - 1];
    end
  end

  always_comb begin
    tap = beat_in;
    for (int j = 2; j <= LAT_MAX; j++) begin
      if (lat == 3'(j)) tap = stg[j-2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdv_q <= 1'b0;
    else     rdv_q <= tap;
  end

  assign rd_valid = rdv_q;

  AST_RDV_LAT1: assert property (@(posedge clk) disable iff (rst)
    ((lat == 3'd1) && beat_in) |=> rd_valid); // R10
  AST_RDV_LAT1_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((lat == 3'd1) && !beat_in) |=> !rd_valid); // R10
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int LAT_MAX = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              start_read,
  input  logic              stop,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_valid,
  output logic              rd_valid,
  output logic              mode_err
);
  ord_e             ord;
  logic [COL_W-1:0] len_mask;
  logic             full_page;
  logic [2:0]       lat, lat_q;
  logic             read_beat;

  bcs_mode_reg #(.COL_W(COL_W)) u_mode (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_word(mode_word),
    .ord(ord), .len_mask(len_mask), .full_page(full_page), .lat(lat),
    .err(mode_err)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .start_read(start_read), .stop(stop), .err(mode_err), .ord(ord),
    .len_mask(len_mask), .full_page(full_page), .lat(lat),
    .col_addr(col_addr), .col_valid(col_valid), .read_beat(read_beat),
    .lat_q(lat_q)
  );

  bcs_valid_pipe #(.LAT_MAX(LAT_MAX)) u_pipe (
    .clk(clk), .rst(rst), .beat_in(read_beat), .lat(lat_q),
    .rd_valid(rd_valid)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!col_valid && !rd_valid && !mode_err)); // R11
endmodule

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_we = 1'b0;
  logic [6:0] mode_word = '0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic       start_read = 1'b0;
  logic       stop = 1'b0;
  logic [7:0] col_addr;
  logic       col_valid, rd_valid, mode_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  burst_col_seq dut (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_word(mode_word),
    .start(start), .start_col(start_col), .start_read(start_read), .stop(stop),
    .col_addr(col_addr), .col_valid(col_valid), .rd_valid(rd_valid),
    .mode_err(mode_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_addr(input bit ilv, input int n, input int s, input int k);
    if (ilv) return s ^ k;
    return (s - (s % n)) + (((s % n) + k) % n);
  endfunction

  function automatic bit exp_err(input logic [6:0] w);
    int l, b;
    l = int'(w[6:4]);
    b = int'(w[2:0]);
    if (l < 1 || l > 3) return 1'b1;
    if (b >= 4 && b <= 6) return 1'b1;
    if (w[3] && !(b == 2 || b == 3)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic write_mode(input logic [6:0] w);
    @(negedge clk);
    mode_we = 1'b1; mode_word = w;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  // Runs a fixed-length burst and checks addresses and read-valid timing.
  task automatic run_burst(input bit ilv, input int lcode, input int lat,
                           input int s, input bit rd, input string req);
    int n;
    n = 1 << lcode;
    write_mode({3'(lat), ilv, 3'(lcode)});
    start = 1'b1; start_col = 8'(s); start_read = rd;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i <= n + lat + 1; i++) begin
      chk(col_valid == (i < n), {req, " col_valid"}, col_valid, i < n);
      if (i < n)
        chk(col_addr == 8'(exp_addr(ilv, n, s, i)), req, col_addr, exp_addr(ilv, n, s, i));
      chk(rd_valid == (rd && (i - lat >= 0) && (i - lat < n)), "R10 rd_valid",
          rd_valid, rd && (i - lat >= 0) && (i - lat < n));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!col_valid && !rd_valid && !mode_err, "R11 reset", {col_valid, rd_valid, mode_err}, 0);

    // R2 R3: every mode word
    for (int w = 0; w < 128; w++) begin
      write_mode(7'(w));
      chk(mode_err == exp_err(7'(w)), "R2 mode_err", mode_err, exp_err(7'(w)));
      if (exp_err(7'(w))) begin
        start = 1'b1; start_col = 8'd5; start_read = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!col_valid, "R3 start ignored", col_valid, 0);
        @(negedge clk);
        chk(!rd_valid && !col_valid, "R3 no read beat", rd_valid, 0);
      end
    end

    // R1 R4 R5: sequential fixed lengths from every start
    for (int lc = 0; lc < 4; lc++)
      for (int s = 0; s < 256; s++)
        run_burst(1'b0, lc, 1, s, s[0], "R1 R4 R5 seq");

    // R7: interleave lengths 4 and 8 from every start
    for (int lc = 2; lc < 4; lc++)
      for (int s = 0; s < 256; s++)
        run_burst(1'b1, lc, 2, s, 1'b0, "R7 ilv");

    // R10: read latency sweep
    for (int lat = 1; lat <= 3; lat++) begin
      run_burst(1'b0, 3, lat, 37, 1'b1, "R10 seq lat");
      run_burst(1'b1, 2, lat, 255, 1'b1, "R10 ilv lat");
      run_burst(1'b0, 0, lat, 9, 1'b1, "R10 len1 lat");
      run_burst(1'b0, 3, lat, 70, 1'b0, "R10 write");
    end

    // R6 R8: full page from 250, more than 256 beats, then stop
    write_mode({3'd1, 1'b0, 3'b111});
    start = 1'b1; start_col = 8'd250; start_read = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 300; i++) begin
      chk(col_valid, "R6 full page valid", col_valid, 1);
      chk(col_addr == 8'((250 + i) % 256), "R6 full page addr", col_addr, (250 + i) % 256);
      if (i == 299) stop = 1'b1;
      @(negedge clk);
    end
    stop = 1'b0;
    chk(!col_valid, "R8 stop full page", col_valid, 0);
    chk(rd_valid, "R10 last read beat", rd_valid, 1);
    @(negedge clk);
    chk(!rd_valid && !col_valid, "R8 quiet after stop", rd_valid, 0);

    // R8: stop inside an interleave burst of 8
    write_mode({3'd1, 1'b1, 3'b011});
    start = 1'b1; start_col = 8'h5A; start_read = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(col_valid && col_addr == 8'(8'h5A ^ i), "R8 R7 before stop", col_addr, 8'h5A ^ i);
      if (i == 2) stop = 1'b1;
      @(negedge clk);
    end
    stop = 1'b0;
    chk(!col_valid, "R8 stop fixed burst", col_valid, 0);
    repeat (3) @(negedge clk);

    // R9: restart during a sequential burst of 8
    write_mode({3'd2, 1'b0, 3'b011});
    start = 1'b1; start_col = 8'd10; start_read = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(col_valid && col_addr == 8'(10 + i), "R9 first burst", col_addr, 10 + i);
      if (i == 2) begin start = 1'b1; start_col = 8'd100; end
      @(negedge clk);
    end
    start = 1'b0;
    for (int i = 0; i < 9; i++) begin
      chk(col_valid == (i < 8), "R9 restart valid", col_valid, i < 8);
      if (i < 8) chk(col_addr == 8'(96 + ((4 + i) % 8)), "R9 restart addr", col_addr, 96 + ((4 + i) % 8));
      @(negedge clk);
    end

    // R3: error flag blocks start after a legal burst
    write_mode({3'd0, 1'b0, 3'b010});
    chk(mode_err, "R2 reserved latency", mode_err, 1);
    start = 1'b1; start_col = 8'd3;
    @(negedge clk);
    start = 1'b0;
    chk(!col_valid, "R3 blocked", col_valid, 0);
    write_mode({3'd3, 1'b1, 3'b010});
    chk(!mode_err, "R2 cleared", mode_err, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule